// File: doc/BRIEF.md
# I2C Slave Protocol State Machine

This block is the target side of a two-wire serial bus. It watches already-synchronized clock (SCL) and data (SDA) lines and finds START and STOP conditions. It takes in a 7-bit or a 10-bit address and then either accepts data bytes from the bus or sends bytes onto it. It drives SDA only by pulling it low, through an output enable.

Received bytes leave the block with a one-cycle valid strobe. Bytes to send are taken from a byte-wide input, and a one-cycle strobe reports that a byte was taken. The host can refuse incoming data. When it does, the slave answers the byte with a not-acknowledge and then waits for the bus to end or restart the transfer.

The complete controller position is always readable on an 8-bit diagnostic word. The upper nibble holds the major state. The lower nibble holds the bit slot inside the current byte.

Top module: `i2c_slave_fsm`

## Requirements
- R1: While reset is asserted, and right after it, `diag_state` reads 0x00 and `sda_oe` is 0.
- R2: A START (SDA falling while SCL is high) moves the block to major state 0x1 on the next cycle, from any state, including a repeated START inside a transfer. The first SCL fall after it enters major state 0xA (first address byte) with slot 0.
- R3: In 7-bit mode, a first byte whose upper seven bits (MSB first) equal `own_addr[6:0]` and whose bit 0 (read/write) is 0 is acknowledged. Each following byte is acknowledged, presented on `rx_data` with a one-cycle `rx_valid`, and the block sits in major state 0x9.
- R4: In 7-bit mode, a matching first byte with bit 0 = 1 is acknowledged and enters major state 0x8. Bytes are taken from `tx_data` when `tx_taken` pulses and are sent MSB first. A new byte is loaded after each acknowledge from the bus master.
- R5: An address that does not match moves the block to major state 0x2 with no acknowledge. Until the next START or STOP, `sda_oe` stays 0 and `rx_valid` never pulses.
- R6: When `rx_refuse` is 1 as a data byte completes, the byte is still delivered, but the slave leaves SDA released in the acknowledge slot. It then sits in major state 0x3 until a STOP or repeated START.
- R7: In 10-bit mode, a first byte of 11110, then `own_addr[9:8]`, then 0 is acknowledged and leads to major state 0xB. A second byte equal to `own_addr[7:0]` is acknowledged and leads to receive (0x9). A second byte that differs leads to 0x2.
- R8: After a full 10-bit address match, a repeated START followed by the same header with bit 0 = 1 is acknowledged and enters transmit (0x8). Without an earlier full match, that header leads to 0x2.
- R9: In states 0x8 to 0xB the low nibble of `diag_state` counts the bit slot, from 0 to 7 for bits and 8 for the acknowledge slot. In all other states it is 0. The slot advances on each SCL fall.
- R10: A STOP (SDA rising while SCL is high) returns `diag_state` to 0x00 on the next cycle, from any state.
- R11: While `enable` is 0, `diag_state` reads 0x00 and `sda_oe` is 0.
- R12: A not-acknowledge from the bus master after a transmitted byte moves the block to major state 0x3, and no further byte is taken.
- R13: SDA is sampled on SCL rising edges. `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; 0 forces idle |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | 10 | Own slave address |
| addr10_en | input | 1 | 1 selects 10-bit addressing |
| tx_data | input | 8 | Next byte to send |
| tx_taken | output | 1 | One-cycle strobe: tx_data was captured |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe: rx_data is new |
| rx_refuse | input | 1 | 1 answers received data with not-acknowledge |
| diag_state | output | 8 | Major state (high nibble) and bit slot (low nibble) |

## Verification
The main function is exercised with several bus patterns:
- a 7-bit write and a 7-bit read, which separate the receive and transmit paths picked by the read/write bit;
- a 10-bit write followed by a repeated-START read, which shows whether the full-match memory survives the restart;
- a wrong address and a wrong second byte of a 10-bit address, which show that both mismatch points lead to the bystander state without driving SDA;
- a refused byte followed by a repeated START, which separates the post-not-acknowledge wait from a plain stop.

STOP in the middle of a byte and disable in the middle of a byte probe the forced returns to idle. Slot-by-slot reads of the diagnostic word confirm where each bit is counted.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  typedef enum logic [3:0] {
    MJ_IDLE    = 4'h0,
    MJ_START   = 4'h1,
    MJ_BYSTAND = 4'h2,
    MJ_WAIT    = 4'h3,
    MJ_TX      = 4'h8,
    MJ_RX      = 4'h9,
    MJ_ADR1    = 4'hA,
    MJ_ADR2    = 4'hB
  } major_e;

  localparam logic [4:0] HDR10_PREFIX = 5'b11110;
endpackage

// File: rtl/i2c_slv_cond.sv
module i2c_slv_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_slv_shift.sv
module i2c_slv_shift #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned SLOT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_i,
  output logic [SLOT_W-1:0] slot,
  output logic [DATA_W-1:0] shreg,
  output logic              ack_hi
);
  localparam logic [SLOT_W-1:0] ACK_SLOT = SLOT_W'(DATA_W);

  logic [SLOT_W-1:0] slot_n;
  logic              slot_en, sh_en, ack_en;

  always_comb begin
    slot_en = ~run | scl_fall;
    if (!run)                slot_n = '0;
    else if (slot == ACK_SLOT) slot_n = '0;
    else                     slot_n = slot + 1'b1;
    sh_en  = run & scl_rise & (slot != ACK_SLOT);
    ack_en = run & scl_rise & (slot == ACK_SLOT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot   <= '0;
      shreg  <= '0;
      ack_hi <= 1'b0;
    end else begin
      if (slot_en) slot   <= slot_n;
      if (sh_en)   shreg  <= {shreg[DATA_W-2:0], sda_i};
      if (ack_en)  ack_hi <= sda_i;
    end
  end
endmodule

// File: rtl/i2c_slv_match.sv
module i2c_slv_match #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 10
) (
  input  logic [DATA_W-1:0] shreg,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              mode10,
  output logic              hdr_hit,
  output logic              lo_hit,
  output logic              rw
);
  import i2c_slv_pkg::*;

  logic hit7, hit10;

  always_comb begin
    hit7    = (shreg[DATA_W-1:1] == own_addr[DATA_W-2:0]);
    hit10   = (shreg[DATA_W-1:3] == HDR10_PREFIX) &&
              (shreg[2:1] == own_addr[ADDR_W-1 -: 2]);
    hdr_hit = mode10 ? hit10 : hit7;
    lo_hit  = (shreg == own_addr[DATA_W-1:0]);
    rw      = shreg[0];
  end
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned SLOT_W = $clog2(DATA_W + 1),
  localparam int unsigned IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              addr10_en,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_taken,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_refuse,
  output logic [7:0]        diag_state
);
  import i2c_slv_pkg::*;

  localparam logic [SLOT_W-1:0] ACK_SLOT  = SLOT_W'(DATA_W);
  localparam logic [SLOT_W-1:0] LAST_BIT  = SLOT_W'(DATA_W - 1);

  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic scl_rise, scl_fall, start_det, stop_det;

  i2c_slv_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_q),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  major_e            major, major_n;
  logic              byte_st;
  logic [SLOT_W-1:0] slot;
  logic [DATA_W-1:0] shreg;
  logic              ack_hi;

  assign byte_st = major[3];

  i2c_slv_shift #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_q),
    .run      (byte_st & enable),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_i    (sda_i),
    .slot     (slot),
    .shreg    (shreg),
    .ack_hi   (ack_hi)
  );

  logic hdr_hit, lo_hit, rw;

  i2c_slv_match #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_match (
    .shreg    (shreg),
    .own_addr (own_addr),
    .mode10   (addr10_en),
    .hdr_hit  (hdr_hit),
    .lo_hit   (lo_hit),
    .rw       (rw)
  );

  logic              ack_oe, ack_oe_n;
  logic              full10, full10_n;
  logic [DATA_W-1:0] tx_byte, tx_byte_n;
  logic [DATA_W-1:0] rx_data_n;
  logic              rx_valid_n, tx_taken_n;
  logic              into_ack, out_ack, load_tx;
  logic [IDX_W-1:0]  bit_idx;
  logic              tx_drive;

  always_comb begin
    into_ack   = scl_fall && (slot == LAST_BIT);
    out_ack    = scl_fall && (slot == ACK_SLOT);
    major_n    = major;
    ack_oe_n   = ack_oe;
    full10_n   = full10;
    rx_data_n  = rx_data;
    rx_valid_n = 1'b0;
    load_tx    = 1'b0;

    if (!enable) begin
      major_n  = MJ_IDLE;
      ack_oe_n = 1'b0;
      full10_n = 1'b0;
    end else if (stop_det) begin
      major_n  = MJ_IDLE;
      ack_oe_n = 1'b0;
      full10_n = 1'b0;
    end else if (start_det) begin
      major_n  = MJ_START;
      ack_oe_n = 1'b0;
    end else begin
      unique case (major)
        MJ_START: if (scl_fall) major_n = MJ_ADR1;
        MJ_ADR1: begin
          if (into_ack) begin
            if (hdr_hit && (!addr10_en || !rw || full10)) begin
              ack_oe_n = 1'b1;
            end else begin
              major_n  = MJ_BYSTAND;
              full10_n = 1'b0;
            end
          end else if (out_ack) begin
            ack_oe_n = 1'b0;
            if (addr10_en && !rw) begin
              major_n = MJ_ADR2;
            end else if (rw) begin
              major_n = MJ_TX;
              load_tx = 1'b1;
            end else begin
              major_n = MJ_RX;
            end
          end
        end
        MJ_ADR2: begin
          if (into_ack) begin
            if (lo_hit) begin
              ack_oe_n = 1'b1;
              full10_n = 1'b1;
            end else begin
              major_n  = MJ_BYSTAND;
              full10_n = 1'b0;
            end
          end else if (out_ack) begin
            ack_oe_n = 1'b0;
            major_n  = MJ_RX;
          end
        end
        MJ_RX: begin
          if (into_ack) begin
            rx_data_n  = shreg;
            rx_valid_n = 1'b1;
            ack_oe_n   = ~rx_refuse;
          end else if (out_ack) begin
            ack_oe_n = 1'b0;
            major_n  = ack_oe ? MJ_RX : MJ_WAIT;
          end
        end
        MJ_TX: begin
          if (out_ack) begin
            if (ack_hi) begin
              major_n = MJ_WAIT;
            end else begin
              load_tx = 1'b1;
            end
          end
        end
        default: major_n = major;
      endcase
    end

    tx_byte_n  = load_tx ? tx_data : tx_byte;
    tx_taken_n = load_tx;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      major    <= MJ_IDLE;
      ack_oe   <= 1'b0;
      full10   <= 1'b0;
      tx_byte  <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      tx_taken <= 1'b0;
    end else begin
      major    <= major_n;
      ack_oe   <= ack_oe_n;
      full10   <= full10_n;
      tx_byte  <= tx_byte_n;
      rx_data  <= rx_data_n;
      rx_valid <= rx_valid_n;
      tx_taken <= tx_taken_n;
    end
  end

  always_comb begin
    bit_idx  = IDX_W'(DATA_W - 1) - IDX_W'(slot);
    tx_drive = (major == MJ_TX) && (slot != ACK_SLOT) && !tx_byte[bit_idx];
  end

  assign sda_oe     = ack_oe | tx_drive;
  assign diag_state = {major, byte_st ? 4'(slot) : 4'h0};
endmodule

// File: rtl/i2c_slave_fsm_chk.sv
module i2c_slave_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       scl_i,
  input logic       sda_oe,
  input logic [7:0] diag_state,
  input logic       start_det,
  input logic       stop_det
);
  // R9
  legal_major_chk: assert property (@(posedge clk) disable iff (!rst_n)
    diag_state[7:4] inside {4'h0, 4'h1, 4'h2, 4'h3, 4'h8, 4'h9, 4'hA, 4'hB});

  // R9
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    diag_state[3:0] <= 4'd8);

  // R9
  slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !diag_state[7] |-> diag_state[3:0] == 4'h0);

  // R2
  start_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && enable) |=> diag_state == 8'h10);

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> diag_state == 8'h00);

  // R11
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (diag_state == 8'h00) && !sda_oe);

  // R5
  bystander_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    diag_state[7:4] == 4'h2 |-> !sda_oe);

  // R13
  sda_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !$stable(sda_oe)) |-> !scl_i);
endmodule

bind i2c_slave_fsm i2c_slave_fsm_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .scl_i      (scl_i),
  .sda_oe     (sda_oe),
  .diag_state (diag_state),
  .start_det  (start_det),
  .stop_det   (stop_det)
);

// File: tb/i2c_slave_fsm_test.sv
module i2c_slave_fsm_test;
  localparam int Q = 5;

  logic       clk = 1'b0;
  logic       rst_n, enable, scl_i, sda_m, addr10_en, rx_refuse;
  logic [9:0] own_addr;
  logic [7:0] tx_data = 8'h00;
  wire        sda_oe, tx_taken, rx_valid, sda_i;
  wire  [7:0] rx_data, diag_state;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_rx[$];
  logic [7:0] tx_q[$];

  always #10 clk = ~clk;

  assign sda_i = sda_m & ~sda_oe;

  i2c_slave_fsm uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scl_i(scl_i), .sda_i(sda_i),
    .sda_oe(sda_oe), .own_addr(own_addr), .addr10_en(addr10_en),
    .tx_data(tx_data), .tx_taken(tx_taken), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_refuse(rx_refuse), .diag_state(diag_state)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_diag(input string req, input logic [7:0] exp);
    chk(diag_state == exp, req, 32'(diag_state), 32'(exp));
  endtask

  // Scoreboard monitor: received bytes and transmit-byte supply.
  always @(negedge clk) begin
    if (rx_valid) begin
      if (exp_rx.size() == 0) begin
        chk(1'b0, "R3/R5 unexpected rx_valid", 32'(rx_data), 32'h0);
      end else begin
        logic [7:0] e;
        e = exp_rx.pop_front();
        chk(rx_data == e, "R3 rx_data", 32'(rx_data), 32'(e));
      end
    end
    if (tx_taken && tx_q.size() > 0) void'(tx_q.pop_front());
    tx_data = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_i = 1'b1; wq();
    sda_m = 1'b0; wq();
    chk_diag("R2 start state", 8'h10);
    scl_i = 1'b0; wq();
    chk_diag("R2 first address slot", 8'hA0);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_i = 1'b1; wq(); sda_m = 1'b1; wq();
    chk_diag("R10 idle after stop", 8'h00);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(); scl_i = 1'b1; wq(); wq(); scl_i = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    logic b2;
    sda_m = 1'b1; wq(); scl_i = 1'b1; wq();
    b = sda_i; wq();
    b2 = sda_i;
    chk(b == b2, "R13 sda stable while scl high", 32'(b2), 32'(b));
    scl_i = 1'b0; wq();
  endtask

  task automatic write_byte(input logic [7:0] d, input logic [3:0] maj,
                            output logic acked);
    logic b;
    for (int i = 0; i < 8; i++) begin
      if (maj != 4'h0) chk_diag("R9 bit slot", {maj, 4'(i)});
      put_bit(d[7-i]);
    end
    if (maj != 4'h0) chk_diag("R9 ack slot", {maj, 4'h8});
    get_bit(b);
    acked = ~b;
  endtask

  task automatic read_byte(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int i = 0; i < 8; i++) begin
      get_bit(b);
      d[7-i] = b;
    end
    put_bit(~give_ack);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic       ak;
    logic [7:0] rd;
    rst_n = 1'b0; enable = 1'b1; scl_i = 1'b1; sda_m = 1'b1;
    addr10_en = 1'b0; rx_refuse = 1'b0; own_addr = 10'h02C;
    repeat (4) @(negedge clk);
    chk_diag("R1 diag in reset", 8'h00);
    chk(sda_oe == 1'b0, "R1 sda_oe in reset", 32'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_diag("R1 diag after reset", 8'h00);

    // R3: 7-bit write
    bus_start();
    write_byte(8'h58, 4'hA, ak);
    chk(ak, "R3 address ack", 32'(ak), 1);
    chk_diag("R3 receive state", 8'h90);
    exp_rx.push_back(8'hA5);
    write_byte(8'hA5, 4'h9, ak);
    chk(ak, "R3 data ack", 32'(ak), 1);
    exp_rx.push_back(8'h3C);
    write_byte(8'h3C, 4'h9, ak);
    chk(ak, "R3 data ack 2", 32'(ak), 1);
    bus_stop();

    // R4 / R12: 7-bit read
    tx_q.push_back(8'h96); tx_q.push_back(8'h41);
    wq();
    bus_start();
    write_byte(8'h59, 4'hA, ak);
    chk(ak, "R4 read address ack", 32'(ak), 1);
    chk_diag("R4 transmit state", 8'h80);
    read_byte(rd, 1'b1);
    chk(rd == 8'h96, "R4 first byte", 32'(rd), 32'h96);
    read_byte(rd, 1'b0);
    chk(rd == 8'h41, "R4 second byte", 32'(rd), 32'h41);
    chk_diag("R12 wait after master nack", 8'h30);
    chk(tx_q.size() == 0, "R12 two bytes taken", 32'(tx_q.size()), 0);
    bus_stop();

    // R5: address mismatch
    bus_start();
    write_byte(8'h5A, 4'h0, ak);
    chk(!ak, "R5 no ack on mismatch", 32'(ak), 0);
    chk_diag("R5 bystander", 8'h20);
    write_byte(8'h00, 4'h0, ak);
    chk(!ak, "R5 bystander never drives", 32'(ak), 0);
    chk_diag("R5 still bystander", 8'h20);
    bus_stop();

    // R6: refused byte, then repeated start
    rx_refuse = 1'b1;
    bus_start();
    write_byte(8'h58, 4'hA, ak);
    exp_rx.push_back(8'h77);
    write_byte(8'h77, 4'h9, ak);
    chk(!ak, "R6 nack sent", 32'(ak), 0);
    chk_diag("R6 wait state", 8'h30);
    rx_refuse = 1'b0;
    bus_start();
    write_byte(8'h58, 4'hA, ak);
    chk(ak, "R6 ack after restart", 32'(ak), 1);
    exp_rx.push_back(8'h11);
    write_byte(8'h11, 4'h9, ak);
    chk(ak, "R6 data after restart", 32'(ak), 1);
    bus_stop();

    // R7 / R8: 10-bit write then read
    addr10_en = 1'b1; own_addr = 10'h2B5;
    tx_q.push_back(8'h5E);
    bus_start();
    write_byte(8'hF4, 4'hA, ak);
    chk(ak, "R7 header ack", 32'(ak), 1);
    chk_diag("R7 second address state", 8'hB0);
    write_byte(8'hB5, 4'hB, ak);
    chk(ak, "R7 low byte ack", 32'(ak), 1);
    chk_diag("R7 receive state", 8'h90);
    exp_rx.push_back(8'hC3);
    write_byte(8'hC3, 4'h9, ak);
    chk(ak, "R7 data ack", 32'(ak), 1);
    bus_start();
    write_byte(8'hF5, 4'hA, ak);
    chk(ak, "R8 read header ack", 32'(ak), 1);
    chk_diag("R8 transmit state", 8'h80);
    read_byte(rd, 1'b0);
    chk(rd == 8'h5E, "R8 byte sent", 32'(rd), 32'h5E);
    bus_stop();

    // R7: 10-bit low byte mismatch; R8: read header without full match
    bus_start();
    write_byte(8'hF4, 4'hA, ak);
    write_byte(8'hB4, 4'h0, ak);
    chk(!ak, "R7 low byte mismatch", 32'(ak), 0);
    chk_diag("R7 bystander", 8'h20);
    bus_start();
    write_byte(8'hF5, 4'h0, ak);
    chk(!ak, "R8 read header refused", 32'(ak), 0);
    chk_diag("R8 bystander", 8'h20);
    bus_stop();

    // R10: stop mid byte
    addr10_en = 1'b0; own_addr = 10'h02C;
    bus_start();
    write_byte(8'h58, 4'hA, ak);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    chk_diag("R9 mid byte slot", 8'h94);
    bus_stop();

    // R11: disable mid byte
    bus_start();
    write_byte(8'h58, 4'hA, ak);
    for (int i = 0; i < 3; i++) put_bit(1'b0);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    chk_diag("R11 disabled idle", 8'h00);
    chk(sda_oe == 1'b0, "R11 sda released", 32'(sda_oe), 0);
    enable = 1'b1;
    bus_stop();

    chk(exp_rx.size() == 0, "R3 all bytes delivered", 32'(exp_rx.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule